// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block holds the interrupt logic for a single bank of general-purpose pins. Software configures each pin, through a small word-addressed register bus, to raise an event on a high level, a low level, a rising edge, a falling edge or on any change. Detected events are latched into a sticky per-pin status register. Software clears a status bit by writing a one to it.

A per-pin mask decides which pending bits reach the single combined interrupt output. The mask is never written directly. One write-only port clears mask bits and a second write-only port sets them. Masking only blocks propagation to the output: detection and status latching go on behind it. If a pin collects a pending bit while masked and is later unmasked, the output rises at once unless software cleared the bit first.

Pin inputs arrive already synchronized to the block clock. Data, direction and the merging of several banks belong to neighbouring logic.

Top module: `gpirq_bank`

## Requirements
- R1: During reset, and in the first cycle after it, every mask bit is 1. Every status, trigger-type, polarity and both-edge bit is 0, and `irq_o` is low.
- R2: A bus write to index 1 (unmask port) clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged. The mask reads at index 0.
- R3: A bus write to index 2 (mask-set port) sets each mask bit whose data bit is 1. Writing all ones masks every pin.
- R4: Status reads at index 3 and bits are sticky. A write to index 3 clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R5: With trigger-type bit 1 (index 4) and both-edge bit 0 (index 6), polarity 1 (index 5) detects a rising edge and polarity 0 detects a falling edge. The edge is found by comparing the pin with its value one cycle earlier, and the status bit is set at the next clock edge.
- R6: With trigger-type 1 and both-edge 1, either edge sets the status bit, whatever the polarity.
- R7: With trigger-type 0, polarity 1 detects a high level and polarity 0 a low level, and the both-edge bit has no effect. While the active level stays present, the status bit is set again every cycle, so a clearing write does not keep it at 0.
- R8: Events set status bits while the pin is masked. Unmasking a pin with a pending bit raises `irq_o` in the cycle after the unmask write.
- R9: `irq_o` is high exactly when some pin has its status bit 1 and its mask bit 0.
- R10: When a clearing write and a new event hit the same status bit in the same cycle, the bit ends up set.
- R11: Writes to index 0 leave the mask unchanged. Reads of the write-only indices 1 and 2, and of the unused index 7, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NPIN | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_rdata | output | NPIN | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default of 32 pins, so the all-ones mask write and every bit position of a full bus word are covered. At this width each of the five trigger encodings can sit on a different pin in the same run, and a random phase mixes them across all pins. Clear-versus-event collisions and level re-assertion occur naturally in that phase. The directed part places unmasking after masked detection and a clear that coincides with a new edge.

// File: rtl/gpirq_pkg.sv
// Shared register index encoding for the GPIO bank interrupt detector.
// Assumes a word-indexed bus with one register per index.
package gpirq_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_MASK    = 3'd0,
        RG_UNMASK  = 3'd1,
        RG_MASKSET = 3'd2,
        RG_STATUS  = 3'd3,
        RG_TRIG    = 3'd4,
        RG_POL     = 3'd5,
        RG_BOTH    = 3'd6,
        RG_NONE    = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpirq_cfg.sv
// Trigger configuration registers: trigger type (edge/level), polarity and
// both-edge select, one bit per pin. Assumes single-cycle write strobes.
module gpirq_cfg #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_we,
    input  logic            pol_we,
    input  logic            both_we,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] trig_q,
    output logic [NPIN-1:0] pol_q,
    output logic [NPIN-1:0] both_q
);
    // Load each configuration word on its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else begin
            if (trig_we) trig_q <= wdata;
            if (pol_we)  pol_q  <= wdata;
            if (both_we) both_q <= wdata;
        end
    end
endmodule

// File: rtl/gpirq_mask.sv
// Per-pin interrupt mask (1 = masked) changed only through a clear port and
// a set port. Assumes at most one of the two strobes is high in a cycle.
module gpirq_mask #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unmask_we,
    input  logic            maskset_we,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] mask_q
);
    // Reset masks all pins; ones in the data clear or set mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (unmask_we) begin
            mask_q <= mask_q & ~wdata;
        end else if (maskset_we) begin
            mask_q <= mask_q | wdata;
        end
    end
endmodule

// File: rtl/gpirq_detect.sv
// Per-pin event detector. Compares each pin with its value one cycle
// earlier for edges and uses the pin level for level triggers.
// Assumes pin_i is already synchronous to clk.
module gpirq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] trig_q,
    input  logic [NPIN-1:0] pol_q,
    input  logic [NPIN-1:0] both_q,
    output logic [NPIN-1:0] event_o
);
    logic [NPIN-1:0] prev_q;

    // Sample history for edge detection; tracks the pin also during reset.
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic rise;
        logic fall;
        logic edge_hit;
        logic lvl_hit;

        // Classify the pin's behaviour this cycle against its configuration.
        always_comb begin
            rise     = pin_i[g] & ~prev_q[g];
            fall     = ~pin_i[g] & prev_q[g];
            edge_hit = both_q[g] ? (rise | fall) : (pol_q[g] ? rise : fall);
            lvl_hit  = pol_q[g] ? pin_i[g] : ~pin_i[g];
            event_o[g] = trig_q[g] ? edge_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpirq_status.sv
// Sticky per-pin status, cleared by write-one. A new event in the same
// cycle as a clear keeps the bit set.
module gpirq_status #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_we,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] event_i,
    output logic [NPIN-1:0] status_q
);
    logic [NPIN-1:0] clr_bits;

    // Bits requested for clearing this cycle.
    always_comb begin
        clr_bits = clr_we ? wdata : '0;
    end

    // Apply the clear, then let events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | event_i;
        end
    end
endmodule

// File: rtl/gpirq_bank.sv
// Interrupt detector for one GPIO bank: decodes bus writes, holds trigger
// configuration, mask and sticky status, and drives one combined request.
// Assumes bus_wr is a one-cycle strobe and reads have no side effects.
module gpirq_bank
    import gpirq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    output logic              irq_o
);
    reg_sel_e        sel;
    logic            unmask_we;
    logic            maskset_we;
    logic            status_we;
    logic            trig_we;
    logic            pol_we;
    logic            both_we;
    logic [NPIN-1:0] trig_q;
    logic [NPIN-1:0] pol_q;
    logic [NPIN-1:0] both_q;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] status_q;
    logic [NPIN-1:0] det_event;

    // Decode the register index into per-register write strobes.
    always_comb begin
        sel        = reg_sel_e'(bus_addr);
        unmask_we  = bus_wr && (sel == RG_UNMASK);
        maskset_we = bus_wr && (sel == RG_MASKSET);
        status_we  = bus_wr && (sel == RG_STATUS);
        trig_we    = bus_wr && (sel == RG_TRIG);
        pol_we     = bus_wr && (sel == RG_POL);
        both_we    = bus_wr && (sel == RG_BOTH);
    end

    gpirq_cfg #(.NPIN(NPIN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_we (trig_we),
        .pol_we  (pol_we),
        .both_we (both_we),
        .wdata   (bus_wdata),
        .trig_q  (trig_q),
        .pol_q   (pol_q),
        .both_q  (both_q)
    );

    gpirq_mask #(.NPIN(NPIN)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmask_we  (unmask_we),
        .maskset_we (maskset_we),
        .wdata      (bus_wdata),
        .mask_q     (mask_q)
    );

    gpirq_detect #(.NPIN(NPIN)) u_det (
        .clk     (clk),
        .pin_i   (pin_i),
        .trig_q  (trig_q),
        .pol_q   (pol_q),
        .both_q  (both_q),
        .event_o (det_event)
    );

    gpirq_status #(.NPIN(NPIN)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (status_we),
        .wdata    (bus_wdata),
        .event_i  (det_event),
        .status_q (status_q)
    );

    // Read multiplexer; write-only and unused indices return zero.
    always_comb begin
        case (sel)
            RG_MASK:   bus_rdata = mask_q;
            RG_STATUS: bus_rdata = status_q;
            RG_TRIG:   bus_rdata = trig_q;
            RG_POL:    bus_rdata = pol_q;
            RG_BOTH:   bus_rdata = both_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Combined request: any pending bit on an unmasked pin.
    always_comb begin
        irq_o = |(status_q & ~mask_q);
    end
endmodule

// File: rtl/gpirq_bank_chk.sv
// Property checker for gpirq_bank, attached by bind. Observes the bus,
// mask, status and detector outputs.
module gpirq_bank_chk
    import gpirq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   mask_q,
    input logic [NPIN-1:0]   status_q,
    input logic [NPIN-1:0]   det_event,
    input logic              irq_o
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && status_q == '0 && !irq_o)); // R1

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_UNMASK) |=> ((mask_q & $past(bus_wdata)) == '0)); // R2

    AST_MASKSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_MASKSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == RG_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q))); // R4

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (det_event != '0) |=> ((status_q & $past(det_event)) == $past(det_event))); // R10

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0 && mask_q != '1)); // R9

    AST_MASK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_MASK) |=> $stable(mask_q)); // R11
endmodule

bind gpirq_bank gpirq_bank_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .det_event (det_event),
    .irq_o     (irq_o)
);

// File: tb/gpirq_bank_bench.sv
module gpirq_bank_bench;
    localparam int  NPIN       = 32;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_i = '1;
    logic            bus_wr = 1'b0;
    logic [2:0]      bus_addr = 3'd0;
    logic [NPIN-1:0] bus_wdata = '0;
    logic [NPIN-1:0] bus_rdata;
    logic            irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic [NPIN-1:0] m_mask, m_stat, m_trig, m_pol, m_both, m_prev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpirq_bank #(.NPIN(NPIN)) u_gpirq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [NPIN-1:0] act,
                       input logic [NPIN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Trigger decoding per R5, R6, R7
    function automatic logic [NPIN-1:0] ev_f(input logic [NPIN-1:0] pin, prev, trig, pol, both);
        logic [NPIN-1:0] rise, fall, edg, lvl;
        rise = pin & ~prev;
        fall = ~pin & prev;
        edg  = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
        lvl  = (pol & pin) | (~pol & ~pin);
        return (trig & edg) | (~trig & lvl);
    endfunction

    // One clock with the currently driven inputs; then compare status and irq.
    task automatic step();
        logic [NPIN-1:0] ev, clr, n_mask, n_trig, n_pol, n_both;
        ev     = ev_f(pin_i, m_prev, m_trig, m_pol, m_both);
        clr    = (bus_wr && bus_addr == 3'd3) ? bus_wdata : '0;
        n_mask = m_mask;
        n_trig = m_trig;
        n_pol  = m_pol;
        n_both = m_both;
        if (bus_wr) begin
            case (bus_addr)
                3'd1: n_mask = m_mask & ~bus_wdata;
                3'd2: n_mask = m_mask | bus_wdata;
                3'd4: n_trig = bus_wdata;
                3'd5: n_pol  = bus_wdata;
                3'd6: n_both = bus_wdata;
                default: ;
            endcase
        end
        @(posedge clk);
        m_stat = (m_stat & ~clr) | ev;
        m_mask = n_mask;
        m_trig = n_trig;
        m_pol  = n_pol;
        m_both = n_both;
        m_prev = pin_i;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 3'd3;
        #1;
        chk(bus_rdata === m_stat, "R4 status", bus_rdata, m_stat);
        chk(irq_o === |(m_stat & ~m_mask), "R9 irq", {31'd0, irq_o}, {31'd0, |(m_stat & ~m_mask)});
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        step();
    endtask

    task automatic rd(input logic [2:0] a, output logic [NPIN-1:0] d);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NPIN-1:0] r;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd0, r); chk(r === '1, "R1 mask", r, '1);
        rd(3'd3, r); chk(r === '0, "R1 status", r, '0);
        rd(3'd4, r); chk(r === '0, "R1 trig", r, '0);
        rd(3'd5, r); chk(r === '0, "R1 pol", r, '0);
        rd(3'd6, r); chk(r === '0, "R1 both", r, '0);
        chk(irq_o === 1'b0, "R1 irq", {31'd0, irq_o}, '0);
        m_mask = '1; m_stat = '0; m_trig = '0; m_pol = '0; m_both = '0; m_prev = pin_i;
        rst_n = 1'b1;
        step();
        rd(3'd0, r); chk(r === '1, "R1 mask after release", r, '1);

        // R2 / R3 mask ports
        wr(3'd1, 32'h0000_00FF);
        rd(3'd0, r); chk(r === 32'hFFFF_FF00, "R2 unmask", r, 32'hFFFF_FF00);
        wr(3'd2, 32'h0000_000F);
        rd(3'd0, r); chk(r === 32'hFFFF_FF0F, "R3 mask set", r, 32'hFFFF_FF0F);
        wr(3'd2, '1);
        rd(3'd0, r); chk(r === '1, "R3 mask all", r, '1);

        // R11 read-only and write-only indices
        wr(3'd0, '0);
        rd(3'd0, r); chk(r === '1, "R11 mask write ignored", r, '1);
        rd(3'd1, r); chk(r === '0, "R11 unmask reads zero", r, '0);
        rd(3'd2, r); chk(r === '0, "R11 maskset reads zero", r, '0);
        rd(3'd7, r); chk(r === '0, "R11 unused reads zero", r, '0);

        // Config: pin0 rising, pin1 falling, pin2 both, pin4 level high
        wr(3'd4, 32'h0000_0007);
        wr(3'd5, 32'h0000_0015);
        pin_i[4] = 1'b0;
        wr(3'd6, 32'h0000_0004);
        wr(3'd3, '1);
        rd(3'd3, r); chk(r === '0, "R4 clear all", r, '0);

        // R5 rising on pin0, masked (R8)
        pin_i[0] = 1'b0; step();
        rd(3'd3, r); chk(r[0] === 1'b0, "R5 falling ignored on rising pin", r, '0);
        pin_i[0] = 1'b1; step();
        rd(3'd3, r); chk(r[0] === 1'b1, "R5 rising sets", r, 32'h1);
        chk(irq_o === 1'b0, "R8 masked no irq", {31'd0, irq_o}, '0);
        pin_i[1] = 1'b0; step();
        rd(3'd3, r); chk(r[1] === 1'b1, "R5 falling sets", r, 32'h3);

        // R8 unmask pending pin0
        wr(3'd1, 32'h1);
        chk(irq_o === 1'b1, "R8 unmask raises irq", {31'd0, irq_o}, 32'h1);
        wr(3'd3, 32'h1);
        chk(irq_o === 1'b0, "R9 masked pending gives no irq", {31'd0, irq_o}, '0);

        // R4 zero bits unaffected
        wr(3'd3, 32'h1);
        rd(3'd3, r); chk(r === 32'h2, "R4 others kept", r, 32'h2);
        wr(3'd3, 32'h2);

        // R6 both edges on pin2
        pin_i[2] = 1'b0; step();
        rd(3'd3, r); chk(r[2] === 1'b1, "R6 fall sets", r, 32'h4);
        wr(3'd3, 32'h4);
        pin_i[2] = 1'b1; step();
        rd(3'd3, r); chk(r[2] === 1'b1, "R6 rise sets", r, 32'h4);
        wr(3'd3, 32'h4);

        // R7 level high on pin4
        pin_i[4] = 1'b1; step();
        rd(3'd3, r); chk(r[4] === 1'b1, "R7 level sets", r, 32'h10);
        wr(3'd3, 32'h10);
        rd(3'd3, r); chk(r[4] === 1'b1, "R7 clear does not stick", r, 32'h10);
        pin_i[4] = 1'b0;
        wr(3'd3, 32'h10);
        rd(3'd3, r); chk(r[4] === 1'b0, "R7 clear after level gone", r, '0);

        // R10 clear and new edge in the same cycle
        pin_i[2] = 1'b0;
        wr(3'd3, 32'h4);
        rd(3'd3, r); chk(r[2] === 1'b1, "R10 event wins", r, 32'h4);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            pin_i = pin_i ^ ($urandom & $urandom & $urandom);
            if ($urandom_range(1, 0) == 1) begin
                bus_wr = 1'b1;
                bus_addr = 3'($urandom_range(7, 0));
                bus_wdata = $urandom;
                if ($urandom_range(3, 0) == 0) bus_wdata = '1;
            end
            step();
        end
        finish_run();
    end
endmodule